// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block produces the interrupt signalling between the two sides of a 2K x 8 shared memory. Each side has one latched mailbox flag, and the flag drives an active-low interrupt line back to that side. The upper two addresses of the 11-bit space are reserved as mailboxes. The right side's mailbox is the top address, 0x7FF. The left side's mailbox is the address just below it, 0x7FE.

A side raises the other side's interrupt by writing the other side's mailbox address. The interrupted side drops its own interrupt by reading its own mailbox address. Data storage in the mailbox locations belongs to the memory array and is not part of this block.

Every access is qualified by that side's busy input from the address arbiter. An access made while busy is asserted does not touch either flag. The access controls are sampled on each rising clock edge. A flag change appears on the interrupt output after that same edge.

Top module: `mbox_irq`

## Requirements
- R1: While reset (rstN low) is applied at a clock edge, both interrupt outputs leftIrqN and rightIrqN are high after that edge.
- R2: A left write (leftCeN=0, leftRwN=0) to address 0x7FF with leftBusyN=1 drives rightIrqN low after the sampling edge.
- R3: A right read (rightCeN=0, rightRwN=1, rightOeN=0) of address 0x7FF with rightBusyN=1 drives rightIrqN high after the edge, unless a set of the right flag occurs in the same cycle.
- R4: A right write (rightCeN=0, rightRwN=0) to address 0x7FE with rightBusyN=1 drives leftIrqN low after the sampling edge.
- R5: A left read (leftCeN=0, leftRwN=1, leftOeN=0) of address 0x7FE with leftBusyN=1 drives leftIrqN high after the edge, unless a set of the left flag occurs in the same cycle.
- R6: A set or clear access made while that side's busy input is low (busyN=0) leaves both interrupt outputs unchanged.
- R7: When a set and a clear of the same flag are accepted in the same cycle, the set wins and the interrupt output is low afterwards.
- R8: Both interrupt outputs are left unchanged by all of the following: accesses to addresses other than 0x7FE and 0x7FF, a side's write to its own mailbox, a side's read of the other side's mailbox, a read with OeN high, and any cycle with CeN high.
- R9: A flag holds its state across idle cycles until a qualifying clear or set occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| leftCeN | input | 1 | Left chip enable, active low |
| leftRwN | input | 1 | Left read/write select (0 = write) |
| leftOeN | input | 1 | Left output enable, active low |
| leftAddr | input | 11 | Left address |
| leftBusyN | input | 1 | Left busy from arbiter, active low |
| rightCeN | input | 1 | Right chip enable, active low |
| rightRwN | input | 1 | Right read/write select (0 = write) |
| rightOeN | input | 1 | Right output enable, active low |
| rightAddr | input | 11 | Right address |
| rightBusyN | input | 1 | Right busy from arbiter, active low |
| leftIrqN | output | 1 | Interrupt toward the left side, active low |
| rightIrqN | output | 1 | Interrupt toward the right side, active low |

## Verification
The assertions check several rules on every clock edge. Each unbusied mailbox write must raise the other side's interrupt. Each unbusied owner read must drop the owner's interrupt when no set competes with it. Any cycle that contains no accepted set or clear for a flag must leave that flag's output steady. Only the directed scenarios show whole message round trips and the persistence of a flag across idle gaps. They also show that a simultaneous set and clear resolves toward the set. Finally, they walk through each individual kind of ignored access, including own-mailbox writes and cross-mailbox reads.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int NUM_SIDES = 2;
  localparam int SIDE_LEFT = 0;
  localparam int SIDE_RIGHT = 1;

  typedef struct packed {
    logic [NUM_SIDES-1:0] setFlag;
    logic [NUM_SIDES-1:0] clrFlag;
  } flag_strobe_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              leftCeN,
  input  logic              leftRwN,
  input  logic              leftOeN,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              leftBusyN,
  input  logic              rightCeN,
  input  logic              rightRwN,
  input  logic              rightOeN,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              rightBusyN,
  output flag_strobe_t      strobe
);
  // Right mailbox at the top address, left mailbox one below.
  localparam logic [ADDR_W-1:0] RIGHT_BOX = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] LEFT_BOX  = {ADDR_W{1'b1}} - ADDR_W'(1);

  logic leftWrOk, leftRdOk, rightWrOk, rightRdOk;

  always_comb begin
    leftWrOk  = !leftCeN && !leftRwN && leftBusyN;
    leftRdOk  = !leftCeN && leftRwN && !leftOeN && leftBusyN;
    rightWrOk = !rightCeN && !rightRwN && rightBusyN;
    rightRdOk = !rightCeN && rightRwN && !rightOeN && rightBusyN;
  end

  always_comb begin
    strobe = '0;
    strobe.setFlag[SIDE_RIGHT] = leftWrOk && (leftAddr == RIGHT_BOX);
    strobe.clrFlag[SIDE_RIGHT] = rightRdOk && (rightAddr == RIGHT_BOX);
    strobe.setFlag[SIDE_LEFT]  = rightWrOk && (rightAddr == LEFT_BOX);
    strobe.clrFlag[SIDE_LEFT]  = leftRdOk && (leftAddr == LEFT_BOX);
  end
endmodule

// File: rtl/mbox_flags.sv
module mbox_flags
  import mbox_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  flag_strobe_t         strobe,
  output logic [NUM_SIDES-1:0] irqN
);
  logic [NUM_SIDES-1:0] flagQ;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)
        flagQ[s] <= 1'b0;
      else if (strobe.setFlag[s])
        flagQ[s] <= 1'b1;        // set has priority over clear
      else if (strobe.clrFlag[s])
        flagQ[s] <= 1'b0;
    end
    assign irqN[s] = ~flagQ[s];
  end
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              leftCeN,
  input  logic              leftRwN,
  input  logic              leftOeN,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              leftBusyN,
  input  logic              rightCeN,
  input  logic              rightRwN,
  input  logic              rightOeN,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              rightBusyN,
  output logic              leftIrqN,
  output logic              rightIrqN
);
  flag_strobe_t         strobe;
  logic [NUM_SIDES-1:0] irqN;

  mbox_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .leftCeN(leftCeN), .leftRwN(leftRwN), .leftOeN(leftOeN),
    .leftAddr(leftAddr), .leftBusyN(leftBusyN),
    .rightCeN(rightCeN), .rightRwN(rightRwN), .rightOeN(rightOeN),
    .rightAddr(rightAddr), .rightBusyN(rightBusyN),
    .strobe(strobe)
  );

  mbox_flags u_flags (
    .clk(clk), .rstN(rstN), .strobe(strobe), .irqN(irqN)
  );

  assign leftIrqN  = irqN[SIDE_LEFT];
  assign rightIrqN = irqN[SIDE_RIGHT];
endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              leftCeN,
  input logic              leftRwN,
  input logic              leftOeN,
  input logic [ADDR_W-1:0] leftAddr,
  input logic              leftBusyN,
  input logic              rightCeN,
  input logic              rightRwN,
  input logic              rightOeN,
  input logic [ADDR_W-1:0] rightAddr,
  input logic              rightBusyN,
  input logic              leftIrqN,
  input logic              rightIrqN
);
  localparam logic [ADDR_W-1:0] TOP_A  = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] NEXT_A = {ADDR_W{1'b1}} - ADDR_W'(1);

  logic lSetsR, rClrR, rSetsL, lClrL;
  assign lSetsR = !leftCeN && !leftRwN && leftBusyN && leftAddr == TOP_A;
  assign rClrR  = !rightCeN && rightRwN && !rightOeN && rightBusyN && rightAddr == TOP_A;
  assign rSetsL = !rightCeN && !rightRwN && rightBusyN && rightAddr == NEXT_A;
  assign lClrL  = !leftCeN && leftRwN && !leftOeN && leftBusyN && leftAddr == NEXT_A;

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rstN |=> (leftIrqN && rightIrqN));
  // R2
  right_set_chk: assert property (@(posedge clk) disable iff (!rstN) lSetsR |=> !rightIrqN);
  // R3
  right_clear_chk: assert property (@(posedge clk) disable iff (!rstN) (rClrR && !lSetsR) |=> rightIrqN);
  // R4
  left_set_chk: assert property (@(posedge clk) disable iff (!rstN) rSetsL |=> !leftIrqN);
  // R5
  left_clear_chk: assert property (@(posedge clk) disable iff (!rstN) (lClrL && !rSetsL) |=> leftIrqN);
  // R8
  right_hold_chk: assert property (@(posedge clk) disable iff (!rstN) (!lSetsR && !rClrR) |=> $stable(rightIrqN));
  // R8
  left_hold_chk: assert property (@(posedge clk) disable iff (!rstN) (!rSetsL && !lClrL) |=> $stable(leftIrqN));
  // R6
  busy_block_chk: assert property (@(posedge clk) disable iff (!rstN) (!leftBusyN && !rightBusyN) |=> ($stable(leftIrqN) && $stable(rightIrqN)));
endmodule

bind mbox_irq mbox_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN),
  .leftCeN(leftCeN), .leftRwN(leftRwN), .leftOeN(leftOeN),
  .leftAddr(leftAddr), .leftBusyN(leftBusyN),
  .rightCeN(rightCeN), .rightRwN(rightRwN), .rightOeN(rightOeN),
  .rightAddr(rightAddr), .rightBusyN(rightBusyN),
  .leftIrqN(leftIrqN), .rightIrqN(rightIrqN)
);

// File: tb/mbox_irq_bench.sv
module mbox_irq_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lCe = 1'b1, lRw = 1'b1, lOe = 1'b1, lBusy = 1'b1;
  logic rCe = 1'b1, rRw = 1'b1, rOe = 1'b1, rBusy = 1'b1;
  logic [10:0] lAddr = '0, rAddr = '0;
  logic leftIrqN, rightIrqN;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mbox_irq u_mbox_irq (
    .clk(clk), .rstN(rstN),
    .leftCeN(lCe), .leftRwN(lRw), .leftOeN(lOe), .leftAddr(lAddr), .leftBusyN(lBusy),
    .rightCeN(rCe), .rightRwN(rRw), .rightOeN(rOe), .rightAddr(rAddr), .rightBusyN(rBusy),
    .leftIrqN(leftIrqN), .rightIrqN(rightIrqN)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic idleAll();
    lCe = 1'b1; lRw = 1'b1; lOe = 1'b1; lBusy = 1'b1; lAddr = '0;
    rCe = 1'b1; rRw = 1'b1; rOe = 1'b1; rBusy = 1'b1; rAddr = '0;
  endtask

  // Inputs are applied at a negedge; one posedge samples them; results read at next negedge.
  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    idleAll();
  endtask

  task automatic leftAcc(input logic rw, input logic oe, input logic [10:0] a, input logic busy);
    lCe = 1'b0; lRw = rw; lOe = oe; lAddr = a; lBusy = busy;
  endtask

  task automatic rightAcc(input logic rw, input logic oe, input logic [10:0] a, input logic busy);
    rCe = 1'b0; rRw = rw; rOe = oe; rAddr = a; rBusy = busy;
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    cycle(); cycle();
    check("R1 left after reset", leftIrqN, 1'b1);
    check("R1 right after reset", rightIrqN, 1'b1);
    rstN = 1'b1;
    cycle();
  endtask

  task automatic t_rightRoundTrip();
    leftAcc(1'b0, 1'b1, 11'h7FF, 1'b1); cycle();
    check("R2 right irq set", rightIrqN, 1'b0);
    check("R2 left irq untouched", leftIrqN, 1'b1);
    cycle(); cycle();
    check("R9 right irq holds", rightIrqN, 1'b0);
    rightAcc(1'b1, 1'b0, 11'h7FF, 1'b1); cycle();
    check("R3 right irq cleared", rightIrqN, 1'b1);
  endtask

  task automatic t_leftRoundTrip();
    rightAcc(1'b0, 1'b1, 11'h7FE, 1'b1); cycle();
    check("R4 left irq set", leftIrqN, 1'b0);
    check("R4 right irq untouched", rightIrqN, 1'b1);
    cycle();
    check("R9 left irq holds", leftIrqN, 1'b0);
    leftAcc(1'b1, 1'b0, 11'h7FE, 1'b1); cycle();
    check("R5 left irq cleared", leftIrqN, 1'b1);
  endtask

  task automatic t_busy();
    leftAcc(1'b0, 1'b1, 11'h7FF, 1'b0); cycle();
    check("R6 busy left write no set", rightIrqN, 1'b1);
    rightAcc(1'b0, 1'b1, 11'h7FE, 1'b0); cycle();
    check("R6 busy right write no set", leftIrqN, 1'b1);
    leftAcc(1'b0, 1'b1, 11'h7FF, 1'b1); rightAcc(1'b0, 1'b1, 11'h7FE, 1'b1); cycle();
    rightAcc(1'b1, 1'b0, 11'h7FF, 1'b0); leftAcc(1'b1, 1'b0, 11'h7FE, 1'b0); cycle();
    check("R6 busy right read no clear", rightIrqN, 1'b0);
    check("R6 busy left read no clear", leftIrqN, 1'b0);
    rightAcc(1'b1, 1'b0, 11'h7FF, 1'b1); leftAcc(1'b1, 1'b0, 11'h7FE, 1'b1); cycle();
    check("R6 unbusy clears right", rightIrqN, 1'b1);
    check("R6 unbusy clears left", leftIrqN, 1'b1);
  endtask

  task automatic t_setWins();
    leftAcc(1'b0, 1'b1, 11'h7FF, 1'b1); rightAcc(1'b1, 1'b0, 11'h7FF, 1'b1); cycle();
    check("R7 right set beats clear", rightIrqN, 1'b0);
    rightAcc(1'b0, 1'b1, 11'h7FE, 1'b1); leftAcc(1'b1, 1'b0, 11'h7FE, 1'b1); cycle();
    check("R7 left set beats clear", leftIrqN, 1'b0);
    rightAcc(1'b1, 1'b0, 11'h7FF, 1'b1); leftAcc(1'b1, 1'b0, 11'h7FE, 1'b1); cycle();
    check("R7 cleanup right", rightIrqN, 1'b1);
    check("R7 cleanup left", leftIrqN, 1'b1);
  endtask

  task automatic t_ignored();
    leftAcc(1'b0, 1'b1, 11'h7FD, 1'b1); rightAcc(1'b0, 1'b1, 11'h000, 1'b1); cycle();
    check("R8 other addr write left", leftIrqN, 1'b1);
    check("R8 other addr write right", rightIrqN, 1'b1);
    leftAcc(1'b0, 1'b1, 11'h7FE, 1'b1); rightAcc(1'b0, 1'b1, 11'h7FF, 1'b1); cycle();
    check("R8 own-box write left", leftIrqN, 1'b1);
    check("R8 own-box write right", rightIrqN, 1'b1);
    lCe = 1'b1; lRw = 1'b0; lAddr = 11'h7FF; rCe = 1'b1; rRw = 1'b0; rAddr = 11'h7FE; cycle();
    check("R8 deselected write left", leftIrqN, 1'b1);
    check("R8 deselected write right", rightIrqN, 1'b1);
    // Raise both flags, then try non-qualifying reads.
    leftAcc(1'b0, 1'b1, 11'h7FF, 1'b1); rightAcc(1'b0, 1'b1, 11'h7FE, 1'b1); cycle();
    leftAcc(1'b1, 1'b0, 11'h7FF, 1'b1); rightAcc(1'b1, 1'b0, 11'h7FE, 1'b1); cycle();
    check("R8 cross-box read left", leftIrqN, 1'b0);
    check("R8 cross-box read right", rightIrqN, 1'b0);
    leftAcc(1'b1, 1'b1, 11'h7FE, 1'b1); rightAcc(1'b1, 1'b1, 11'h7FF, 1'b1); cycle();
    check("R8 oe high read left", leftIrqN, 1'b0);
    check("R8 oe high read right", rightIrqN, 1'b0);
    leftAcc(1'b1, 1'b0, 11'h123, 1'b1); rightAcc(1'b1, 1'b0, 11'h7FD, 1'b1); cycle();
    check("R8 other addr read left", leftIrqN, 1'b0);
    check("R8 other addr read right", rightIrqN, 1'b0);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        idleAll();
        t_reset();
        t_rightRoundTrip();
        t_leftRoundTrip();
        t_busy();
        t_setWins();
        t_ignored();
        t_reset();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule